// File: doc/BRIEF.md
# Dual-Clock FIFO with Five Status Flags

This block is a first-in first-out buffer for 18-bit words. Its write side and its read side each run on their own clock. Each side owns the flags that matter to it. The write side drives full, almost-full and half-full. The read side drives empty and almost-empty. Each flag is a register clocked only by its own side's clock. Write and read positions cross between the two clock domains as Gray codes through two-stage synchronizers. A stale copy can only make a flag more cautious, never less.

Reads can be replayed. While `rd_hold` is high, words that have been read stay in storage and keep counting toward the write-side occupancy. A `rd_retx` pulse moves the read position back to the oldest retained word. While `rd_hold` is low, the retention mark moves forward one entry per read clock until it reaches the read position, which frees the storage. Each almost threshold is an offset held in a register and loaded by a one-cycle strobe in the clock domain that owns it. `rd_oe` gates what is presented: it hides the data and the valid pulse but does not stop a read from consuming a word. The two clocks may be separate or tied to one clock.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: A word on `wr_data` is stored on each rising `wr_clk` edge where `wr_en` is high and `full` is low; holding `wr_en` stores one word per cycle.
- R2: A rising `rd_clk` edge with `rd_en` high, `empty` low and `rd_retx` low consumes the oldest unread word. Right after that edge, `rd_data` shows the word and `rd_valid` is high for one cycle. After reset `rd_valid` is low and `rd_data` is zero.
- R3: A write while `full` is high is dropped: no stored word is overwritten and no extra word is ever read out.
- R4: A read while `empty` is high is dropped: `rd_valid` stays low and the read position does not move.
- R5: `empty` is high after reset. It is high whenever the read side sees no unread word, including right after the edge that consumes the last word. It goes low only after written data has crossed into the read domain.
- R6: `full` is high once the occupancy (words written minus words released) reaches DEPTH. It is updated on the same `wr_clk` edge as the write that fills the buffer, and it is low after reset.
- R7: `half_full` is high while the write-side occupancy is at least DEPTH/2.
- R8: `almost_full` is high while the occupancy is at least DEPTH minus the almost-full offset. The offset resets to AF_INIT and is replaced by `af_offset` on a `wr_clk` edge with `af_load` high.
- R9: `almost_empty` is high while the unread count seen by the read side is at most the almost-empty offset. The offset resets to AE_INIT and is replaced by `ae_offset` on an `rd_clk` edge with `ae_load` high.
- R10: A `rd_retx` pulse sets the read position to the retention mark. The reads that follow return the retained words again, oldest first. If nothing is retained, `empty` stays high.
- R11: While `rd_hold` is high, words that have been read are retained and still count toward `half_full`, `almost_full` and `full`. While it is low, the mark advances one entry per `rd_clk` toward the read position, which frees those words.
- R12: While `rd_oe` is low, `rd_valid` is low and `rd_data` is zero, but a read still consumes its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Word to store |
| af_load | input | 1 | Load strobe for the almost-full offset |
| af_offset | input | log2(DEPTH) | New almost-full offset |
| full | output | 1 | Buffer full (write domain) |
| almost_full | output | 1 | Occupancy at or above DEPTH minus offset |
| half_full | output | 1 | Occupancy at or above DEPTH/2 |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side reset, active low |
| rd_en | input | 1 | Read request |
| rd_oe | input | 1 | Output gate for data and valid |
| rd_hold | input | 1 | Retain read words for replay |
| rd_retx | input | 1 | Rewind the read position to the retention mark |
| ae_load | input | 1 | Load strobe for the almost-empty offset |
| ae_offset | input | log2(DEPTH) | New almost-empty offset |
| rd_data | output | 18 | Word read, zero while gated |
| rd_valid | output | 1 | One-cycle pulse after a consuming read |
| empty | output | 1 | No unread word (read domain) |
| almost_empty | output | 1 | Unread count at or below offset |

## Verification
The assertions assume three things about the inputs. Both resets are applied together. The offsets loaded are below DEPTH. `rd_retx` is not pulsed in the short window after `rd_hold` falls while the mark is still catching up, so a rewind always lands on a mark that is not ahead of the read position. The stimulus ties both clocks to one clock and asserts both resets at once. It loads offsets of 5 and 6 into a 16-entry buffer. It issues rewinds only while holding, or after idling long enough for the mark to reach the read position.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int unsigned DCF_WORD_W = 18;

    typedef logic [DCF_WORD_W-1:0] dcf_word_t;

    function automatic logic [31:0] dcf_bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] dcf_gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b     = '0;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int unsigned W      = 9,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int unsigned DEPTH   = 256,
    parameter int unsigned AF_INIT = 8,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          af_ld,
    input  logic [AW-1:0] af_val,
    input  logic [PW-1:0] mark_gray_s,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          almost_full,
    output logic          half_full
);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [AW-1:0] af_off;
        logic          full;
        logic          afull;
        logic          hfull;
    } wr_st_t;

    wr_st_t        st_d, st_q;
    logic [PW-1:0] mark_bin;
    logic [PW-1:0] occ_d;

    always_comb begin
        mark_bin = PW'(dcf_gray2bin(32'(mark_gray_s)));
        wr_fire  = wr_en && !st_q.full;
        st_d     = st_q;
        st_d.ptr  = st_q.ptr + PW'(wr_fire);
        st_d.gray = PW'(dcf_bin2gray(32'(st_d.ptr)));
        if (af_ld) begin
            st_d.af_off = af_val;
        end
        occ_d      = st_d.ptr - mark_bin;
        st_d.full  = occ_d >= PW'(DEPTH);
        st_d.afull = occ_d >= (PW'(DEPTH) - PW'(st_d.af_off));
        st_d.hfull = occ_d >= PW'(DEPTH / 2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, gray: '0, af_off: AW'(AF_INIT),
                      full: 1'b0, afull: 1'b0, hfull: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr       = st_q.ptr[AW-1:0];
    assign wgray       = st_q.gray;
    assign full        = st_q.full;
    assign almost_full = st_q.afull;
    assign half_full   = st_q.hfull;

    AST_FULL_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(st_q.ptr))
        else $error("write accepted while full"); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ptr - mark_bin) <= PW'(DEPTH))
        else $error("occupancy beyond depth"); // R6

    AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (half_full && almost_full))
        else $error("full without half/almost full"); // R7

    AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1)
        else $error("write gray code moved more than one bit"); // R5

endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int unsigned DEPTH   = 256,
    parameter int unsigned AE_INIT = 8,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rd_hold,
    input  logic          retx,
    input  logic          ae_ld,
    input  logic [AW-1:0] ae_val,
    input  logic [PW-1:0] wgray_s,
    output logic          rd_fire,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] mgray,
    output logic          empty,
    output logic          almost_empty
);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] mark;
        logic [PW-1:0] mgray;
        logic [AW-1:0] ae_off;
        logic          empty;
        logic          aempty;
    } rd_st_t;

    rd_st_t        st_d, st_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] unread_d;

    always_comb begin
        wbin    = PW'(dcf_gray2bin(32'(wgray_s)));
        rd_fire = rd_en && !st_q.empty && !retx;
        st_d    = st_q;
        if (retx) begin
            st_d.ptr = st_q.mark;
        end else begin
            st_d.ptr = st_q.ptr + PW'(rd_fire);
        end
        if (!retx && !rd_hold && (st_q.mark != st_q.ptr)) begin
            st_d.mark = st_q.mark + PW'(1);
        end
        st_d.mgray = PW'(dcf_bin2gray(32'(st_d.mark)));
        if (ae_ld) begin
            st_d.ae_off = ae_val;
        end
        unread_d    = wbin - st_d.ptr;
        st_d.empty  = unread_d == '0;
        st_d.aempty = unread_d <= PW'(st_d.ae_off);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, mark: '0, mgray: '0, ae_off: AW'(AE_INIT),
                      empty: 1'b1, aempty: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr        = st_q.ptr[AW-1:0];
    assign mgray        = st_q.mgray;
    assign empty        = st_q.empty;
    assign almost_empty = st_q.aempty;

    AST_EMPTY_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !retx) |=> $stable(st_q.ptr))
        else $error("read accepted while empty"); // R4

    AST_RETX_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        retx |=> (st_q.ptr == $past(st_q.mark)))
        else $error("rewind missed the mark"); // R10

    AST_MARK_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.mgray ^ $past(st_q.mgray)) <= 1)
        else $error("mark gray code moved more than one bit"); // R11

    AST_MARK_BEHIND_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ptr - st_q.mark) <= PW'(DEPTH))
        else $error("mark ahead of read position"); // R11

    AST_EMPTY_IMPLIES_AE: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty)
        else $error("empty without almost empty"); // R9

endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
    import dcf_pkg::*;
#(
    parameter int unsigned DEPTH       = 256,
    parameter int unsigned AF_INIT     = 8,
    parameter int unsigned AE_INIT     = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AW         = $clog2(DEPTH),
    localparam int unsigned PW         = AW + 1
) (
    input  logic                  wr_clk,
    input  logic                  wr_rst_n,
    input  logic                  wr_en,
    input  logic [DCF_WORD_W-1:0] wr_data,
    input  logic                  af_load,
    input  logic [AW-1:0]         af_offset,
    output logic                  full,
    output logic                  almost_full,
    output logic                  half_full,
    input  logic                  rd_clk,
    input  logic                  rd_rst_n,
    input  logic                  rd_en,
    input  logic                  rd_oe,
    input  logic                  rd_hold,
    input  logic                  rd_retx,
    input  logic                  ae_load,
    input  logic [AW-1:0]         ae_offset,
    output logic [DCF_WORD_W-1:0] rd_data,
    output logic                  rd_valid,
    output logic                  empty,
    output logic                  almost_empty
);

    typedef struct packed {
        dcf_word_t word;
        logic      vld;
    } out_st_t;

    dcf_word_t     mem [DEPTH];
    logic          wr_fire, rd_fire;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, wgray_s, mgray, mgray_s;
    out_st_t       out_d, out_q;

    dcf_wr_ctrl #(.DEPTH(DEPTH), .AF_INIT(AF_INIT)) u_wr (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .wr_en       (wr_en),
        .af_ld       (af_load),
        .af_val      (af_offset),
        .mark_gray_s (mgray_s),
        .wr_fire     (wr_fire),
        .waddr       (waddr),
        .wgray       (wgray),
        .full        (full),
        .almost_full (almost_full),
        .half_full   (half_full)
    );

    dcf_rd_ctrl #(.DEPTH(DEPTH), .AE_INIT(AE_INIT)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rd_rst_n),
        .rd_en        (rd_en),
        .rd_hold      (rd_hold),
        .retx         (rd_retx),
        .ae_ld        (ae_load),
        .ae_val       (ae_offset),
        .wgray_s      (wgray_s),
        .rd_fire      (rd_fire),
        .raddr        (raddr),
        .mgray        (mgray),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (mgray),
        .q     (mgray_s)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_fire) begin
            mem[waddr] <= wr_data;
        end
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = rd_fire;
        if (rd_fire) begin
            out_d.word = mem[raddr];
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) out_q <= '0;
        else           out_q <= out_d;
    end

    assign rd_data  = rd_oe ? out_q.word : '0;
    assign rd_valid = rd_oe && out_q.vld;

endmodule

// File: tb/dual_clock_flag_fifo_tb.sv
module dual_clock_flag_fifo_tb;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DEPTH      = 16;
    localparam int unsigned AW         = $clog2(DEPTH);
    localparam int unsigned NVEC       = 8;
    localparam logic [17:0] VEC [NVEC] = '{18'h00001, 18'h3FFFF, 18'h2AAAA,
        18'h15555, 18'h00000, 18'h12345, 18'h0F0F0, 18'h20001};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, af_load = 1'b0, ae_load = 1'b0;
    logic          rd_en = 1'b0, rd_oe = 1'b1, rd_hold = 1'b0, rd_retx = 1'b0;
    logic [17:0]   wr_data = '0;
    logic [AW-1:0] af_offset = '0, ae_offset = '0;
    logic [17:0]   rd_data;
    logic          full, almost_full, half_full, rd_valid, empty, almost_empty;
    int            checks = 0;
    int            errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_clock_flag_fifo #(.DEPTH(DEPTH), .AF_INIT(2), .AE_INIT(2)) u_dut (
        .wr_clk (clk), .wr_rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .af_load (af_load), .af_offset (af_offset),
        .full (full), .almost_full (almost_full), .half_full (half_full),
        .rd_clk (clk), .rd_rst_n (rst_n), .rd_en (rd_en), .rd_oe (rd_oe),
        .rd_hold (rd_hold), .rd_retx (rd_retx),
        .ae_load (ae_load), .ae_offset (ae_offset),
        .rd_data (rd_data), .rd_valid (rd_valid),
        .empty (empty), .almost_empty (almost_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [17:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_chk(input logic [17:0] exp, input string req);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk({req, " valid"}, 32'(rd_valid), 32'd1);
        chk({req, " data"}, 32'(rd_data), 32'(exp));
    endtask

    task automatic retx_pulse();
        rd_retx = 1'b1;
        @(negedge clk);
        rd_retx = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R5 empty after reset", 32'(empty), 32'd1);
        chk("R9 almost_empty after reset", 32'(almost_empty), 32'd1);
        chk("R6 full after reset", 32'(full), 32'd0);
        chk("R7 half_full after reset", 32'(half_full), 32'd0);
        chk("R8 almost_full after reset", 32'(almost_full), 32'd0);
        chk("R2 valid after reset", 32'(rd_valid), 32'd0);
        chk("R2 data after reset", 32'(rd_data), 32'd0);

        // vector table: write all, then read back in order
        for (int i = 0; i < NVEC; i++) push(VEC[i]);
        chk("R7 half_full at depth/2", 32'(half_full), 32'd1);
        chk("R8 almost_full below threshold", 32'(almost_full), 32'd0);
        idle(5);
        chk("R5 empty cleared after writes", 32'(empty), 32'd0);
        for (int i = 0; i < NVEC; i++) pop_chk(VEC[i], "R1 R2 table word");
        chk("R5 empty after last read", 32'(empty), 32'd1);

        // read while empty
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R4 no valid on empty read", 32'(rd_valid), 32'd0);
        idle(5);
        chk("R7 half_full cleared after drain", 32'(half_full), 32'd0);

        // fill to full, then overflow attempt
        for (int i = 0; i < DEPTH; i++) begin
            push(18'h100 + 18'(i));
            if (i + 1 == 13) chk("R8 almost_full at 13", 32'(almost_full), 32'd0);
            if (i + 1 == 14) chk("R8 almost_full at 14", 32'(almost_full), 32'd1);
            if (i + 1 == 15) chk("R6 not full at 15", 32'(full), 32'd0);
        end
        chk("R6 full at depth", 32'(full), 32'd1);
        push(18'h3FFFF);
        chk("R3 still full after dropped write", 32'(full), 32'd1);
        idle(5);
        for (int i = 0; i < DEPTH; i++) begin
            pop_chk(18'h100 + 18'(i), "R3 data intact");
            if (i + 1 == 13) chk("R9 almost_empty with 3 left", 32'(almost_empty), 32'd0);
            if (i + 1 == 14) chk("R9 almost_empty with 2 left", 32'(almost_empty), 32'd1);
        end
        chk("R3 no extra word stored", 32'(empty), 32'd1);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R3 no extra word read", 32'(rd_valid), 32'd0);

        // programmed offsets
        idle(5);
        af_load = 1'b1; af_offset = AW'(5);
        ae_load = 1'b1; ae_offset = AW'(6);
        @(negedge clk);
        af_load = 1'b0; ae_load = 1'b0;
        for (int i = 0; i < 11; i++) begin
            push(18'h200 + 18'(i));
            if (i + 1 == 10) chk("R8 programmed almost_full at 10", 32'(almost_full), 32'd0);
            if (i + 1 == 11) chk("R8 programmed almost_full at 11", 32'(almost_full), 32'd1);
        end
        idle(5);
        chk("R9 programmed almost_empty with 11", 32'(almost_empty), 32'd0);
        for (int i = 0; i < 11; i++) begin
            pop_chk(18'h200 + 18'(i), "R9 programmed data");
            if (i + 1 == 4) chk("R9 programmed almost_empty with 7", 32'(almost_empty), 32'd0);
            if (i + 1 == 5) chk("R9 programmed almost_empty with 6", 32'(almost_empty), 32'd1);
        end

        // output gate
        idle(5);
        rd_oe = 1'b0;
        push(18'h0ABCD);
        idle(5);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R12 valid gated", 32'(rd_valid), 32'd0);
        chk("R12 data gated", 32'(rd_data), 32'd0);
        chk("R12 gated read consumed", 32'(empty), 32'd1);
        rd_oe = 1'b1;

        // retain and replay
        idle(5);
        rd_hold = 1'b1;
        for (int i = 0; i < 8; i++) push(18'h300 + 18'(i));
        idle(5);
        for (int i = 0; i < 8; i++) pop_chk(18'h300 + 18'(i), "R11 first pass");
        idle(5);
        chk("R11 retained words still counted", 32'(half_full), 32'd1);
        chk("R11 nothing unread", 32'(empty), 32'd1);
        retx_pulse();
        chk("R10 rewind makes data available", 32'(empty), 32'd0);
        for (int i = 0; i < 8; i++) pop_chk(18'h300 + 18'(i), "R10 replay");
        rd_hold = 1'b0;
        idle(20);
        chk("R11 release frees storage", 32'(half_full), 32'd0);
        retx_pulse();
        chk("R10 rewind with nothing retained", 32'(empty), 32'd1);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R10 no replay after release", 32'(rd_valid), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule